// File: doc/BRIEF.md
# Vector AES Final-Round Encrypt Legality Decoder

This block inspects a 32-bit instruction word and reports whether it is one of the two vector AES final-round encrypt operations. The two forms are a vector-vector form and a vector-scalar form. When the word is one of them, the block checks it against the live vector configuration and raises an illegal flag if any condition is broken. The conditions cover the selected element width, the register grouping factor, the start index, the vector length and the crypto extension enable.

The block is purely combinational and sits beside a core's main decoder. The variant output tells the issue logic which form was seen. A word that is not one of the two forms reports the variant "none" with the illegal flag low, so other decoders remain free to claim it. A word that matches but breaks a rule reports its variant with the illegal flag high. The caller turns that into an illegal-instruction trap.

Register-group checks depend on the grouping factor, passed as a signed 3-bit value. A value of zero or below means one register per group. A positive value n means 2^n registers per group.

Top module: `vaes_legal_dec`

## Requirements
- R1: A word with bits[31:26]=101000, bit25=1, bits[19:15]=00011, bits[14:12]=010 and bits[6:0]=1110111 is decoded as the vector-vector form. variant_o then reads 3'b010.
- R2: The same word with bits[31:26]=101001 is decoded as the vector-scalar form. variant_o then reads 3'b100.
- R3: Any other word gives variant_o=3'b001 and illegal_o=0. This includes words with bit25=0 or a wrong fixed field.
- R4: A decoded form is illegal unless sew_i equals code 2, which selects 32-bit elements.
- R5: A decoded form is illegal when vstart_i is not a multiple of 4.
- R6: A decoded form is illegal when crypto_en_i is 0.
- R7: The destination index bits[11:7] must be a multiple of 2^lmul when lmul_i (signed) is positive. When lmul_i is zero or negative, no alignment is demanded.
- R8: The vector-vector form also requires the source index bits[24:20] to meet the alignment rule of R7.
- R9: For the vector-scalar form, the source index needs no alignment. The ranges [vd, vd+G-1] and [vs2, vs2+G-1] must not intersect, where G is 1 for lmul_i<=0 and 2^lmul_i otherwise. An intersection makes the word illegal.
- R10: A decoded form is illegal when vl_i is not a multiple of 4.
- R11: variant_o is always exactly one-hot: bit0 means none, bit1 means vector-vector, and bit2 means vector-scalar.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| sew_i | input | 3 | Element-width code (2 = 32 bits) |
| lmul_i | input | 3 | Signed register grouping exponent |
| vstart_i | input | VSTART_W (16) | Current start element index |
| vl_i | input | VL_W (16) | Current vector length |
| crypto_en_i | input | 1 | Vector crypto extension enable |
| variant_o | output | 3 | One-hot form: none / vector-vector / vector-scalar |
| illegal_o | output | 1 | Decoded form violates a legality rule |

## Verification
The bench targets group overlap near its edges for the vector-scalar form. It uses ranges that touch but do not share a register, ranges that share exactly one register, and eight-register groups. An off-by-one interval test would trap legal words or pass overlapping ones. It checks that an unaligned source index is accepted in the vector-scalar form but rejected in the vector-vector form, so a shared check for both forms would fail one of the two. It also checks fractional grouping, which must demand no alignment, and near-miss encodings, which must stay unclaimed rather than flagged illegal.

// File: rtl/vaes_dec_pkg.sv
package vaes_dec_pkg;
   localparam int VAR_W = 3;
   typedef enum logic [VAR_W-1:0] {
      VAR_NONE = 3'b001,
      VAR_VV   = 3'b010,
      VAR_VS   = 3'b100
   } vaes_var_e;

   localparam logic [5:0] F6_VV     = 6'b101000;
   localparam logic [5:0] F6_VS     = 6'b101001;
   localparam logic [4:0] MID_FIELD = 5'b00011;
   localparam logic [2:0] F3_FIELD  = 3'b010;
   localparam logic [6:0] MAJOR_OPC = 7'b1110111;
endpackage

// File: rtl/vaes_opc_match.sv
module vaes_opc_match
   import vaes_dec_pkg::*;
#(
   parameter int ILEN  = 32,
   parameter int IDX_W = 5
) (
   input  logic [ILEN-1:0]  insn_i,
   output logic             is_vv_o,
   output logic             is_vs_o,
   output logic [IDX_W-1:0] vd_o,
   output logic [IDX_W-1:0] vs2_o
);
   generate
      if (ILEN != 32) begin : g_bad_ilen
         $error("vaes_opc_match: ILEN must be 32");
      end
      if (IDX_W != 5) begin : g_bad_idx
         $error("vaes_opc_match: IDX_W must be 5");
      end
   endgenerate

   logic fixed_ok;

   always_comb begin
      fixed_ok = insn_i[25] && (insn_i[19:15] == MID_FIELD) &&
                 (insn_i[14:12] == F3_FIELD) && (insn_i[6:0] == MAJOR_OPC);
      is_vv_o  = fixed_ok && (insn_i[31:26] == F6_VV);
      is_vs_o  = fixed_ok && (insn_i[31:26] == F6_VS);
      vd_o     = insn_i[11:7];
      vs2_o    = insn_i[24:20];
   end

   always_comb begin
      if (!$isunknown(insn_i)) begin
         a_r11_forms_exclusive: assert (!(is_vv_o && is_vs_o))
            else $error("both forms matched");
      end
   end
endmodule

// File: rtl/vaes_grp_size.sv
module vaes_grp_size #(
   parameter int LMUL_W = 3,
   parameter int IDX_W  = 5
) (
   input  logic [LMUL_W-1:0] lmul_i,
   output logic [IDX_W:0]    size_o,
   output logic [IDX_W-1:0]  mask_o
);
   localparam int MAX_EXP = (1 << (LMUL_W-1)) - 1;

   generate
      if (MAX_EXP >= IDX_W) begin : g_bad_lmul
         $error("vaes_grp_size: group could exceed register file");
      end
   endgenerate

   always_comb begin
      if ($signed(lmul_i) > 0) begin
         size_o = (IDX_W+1)'(1) << lmul_i[LMUL_W-2:0];
      end else begin
         size_o = (IDX_W+1)'(1);
      end
      mask_o = IDX_W'(size_o - (IDX_W+1)'(1));
   end

   always_comb begin
      if (!$isunknown(lmul_i)) begin
         a_r9_size_pow2: assert ($countones(size_o) == 1)
            else $error("group size not a power of two");
      end
   end
endmodule

// File: rtl/vaes_grp_check.sv
module vaes_grp_check #(
   parameter int IDX_W         = 5,
   parameter bit CHECK_OVERLAP = 1'b0
) (
   input  logic [IDX_W-1:0] vd_i,
   input  logic [IDX_W-1:0] vs2_i,
   input  logic [IDX_W:0]   size_i,
   input  logic [IDX_W-1:0] mask_i,
   output logic             ok_o
);
   logic vd_aligned;
   assign vd_aligned = (vd_i & mask_i) == '0;

   generate
      if (CHECK_OVERLAP) begin : g_overlap
         logic [IDX_W+1:0] vd_end, vs2_end;
         logic             hit;
         always_comb begin
            vd_end  = {2'b00, vd_i}  + {1'b0, size_i};
            vs2_end = {2'b00, vs2_i} + {1'b0, size_i};
            hit     = ({2'b00, vd_i} < vs2_end) && ({2'b00, vs2_i} < vd_end);
            ok_o    = vd_aligned && !hit;
         end
         always_comb begin
            if (!$isunknown({vd_i, vs2_i}) && ok_o) begin
               a_r9_same_base_rejected: assert (vd_i != vs2_i)
                  else $error("identical groups accepted");
            end
         end
      end else begin : g_align
         logic vs2_aligned;
         logic unused_size;
         always_comb begin
            vs2_aligned = (vs2_i & mask_i) == '0;
            unused_size = ^size_i;
            ok_o        = vd_aligned && vs2_aligned;
         end
      end
   endgenerate
endmodule

// File: rtl/vaes_legal_dec.sv
module vaes_legal_dec
   import vaes_dec_pkg::*;
#(
   parameter int ILEN     = 32,
   parameter int IDX_W    = 5,
   parameter int SEW_W    = 3,
   parameter int LMUL_W   = 3,
   parameter int VSTART_W = 16,
   parameter int VL_W     = 16,
   parameter int SEW_CODE = 2,
   parameter int EGS      = 4
) (
   input  logic [ILEN-1:0]     insn_i,
   input  logic [SEW_W-1:0]    sew_i,
   input  logic [LMUL_W-1:0]   lmul_i,
   input  logic [VSTART_W-1:0] vstart_i,
   input  logic [VL_W-1:0]     vl_i,
   input  logic                crypto_en_i,
   output logic [VAR_W-1:0]    variant_o,
   output logic                illegal_o
);
   localparam int EGS_LOG = $clog2(EGS);

   generate
      if ((1 << EGS_LOG) != EGS) begin : g_bad_egs
         $error("vaes_legal_dec: EGS must be a power of two");
      end
      if (VSTART_W <= EGS_LOG || VL_W <= EGS_LOG) begin : g_bad_w
         $error("vaes_legal_dec: counters too narrow for EGS");
      end
      if (SEW_CODE >= (1 << SEW_W)) begin : g_bad_sew
         $error("vaes_legal_dec: SEW_CODE does not fit SEW_W");
      end
   endgenerate

   logic             is_vv, is_vs;
   logic [IDX_W-1:0] vd, vs2, grp_mask;
   logic [IDX_W:0]   grp_size;
   logic             vv_grp_ok, vs_grp_ok, cfg_ok;

   vaes_opc_match #(.ILEN(ILEN), .IDX_W(IDX_W)) u_match (
      .insn_i(insn_i), .is_vv_o(is_vv), .is_vs_o(is_vs), .vd_o(vd), .vs2_o(vs2)
   );

   vaes_grp_size #(.LMUL_W(LMUL_W), .IDX_W(IDX_W)) u_size (
      .lmul_i(lmul_i), .size_o(grp_size), .mask_o(grp_mask)
   );

   vaes_grp_check #(.IDX_W(IDX_W), .CHECK_OVERLAP(1'b0)) u_chk_vv (
      .vd_i(vd), .vs2_i(vs2), .size_i(grp_size), .mask_i(grp_mask), .ok_o(vv_grp_ok)
   );

   vaes_grp_check #(.IDX_W(IDX_W), .CHECK_OVERLAP(1'b1)) u_chk_vs (
      .vd_i(vd), .vs2_i(vs2), .size_i(grp_size), .mask_i(grp_mask), .ok_o(vs_grp_ok)
   );

   always_comb begin
      cfg_ok = (sew_i == SEW_W'(SEW_CODE)) && crypto_en_i &&
               ((vstart_i & VSTART_W'(EGS-1)) == '0) &&
               ((vl_i & VL_W'(EGS-1)) == '0);
      if (is_vv)      variant_o = VAR_VV;
      else if (is_vs) variant_o = VAR_VS;
      else            variant_o = VAR_NONE;
      illegal_o = (is_vv && !(cfg_ok && vv_grp_ok)) ||
                  (is_vs && !(cfg_ok && vs_grp_ok));
   end

   always_comb begin
      if (!$isunknown({insn_i, sew_i, lmul_i, vstart_i, vl_i, crypto_en_i})) begin
         a_r11_variant_onehot: assert ($onehot(variant_o))
            else $error("variant not one-hot");
         a_r3_foreign_not_flagged: assert (!(variant_o[0] && illegal_o))
            else $error("unclaimed word flagged illegal");
         a_r4_sew_enforced: assert (variant_o[0] || sew_i == SEW_W'(SEW_CODE) || illegal_o)
            else $error("wrong element width accepted");
         a_r6_enable_enforced: assert (variant_o[0] || crypto_en_i || illegal_o)
            else $error("disabled extension accepted");
         a_r10_vl_enforced: assert (variant_o[0] || vl_i[EGS_LOG-1:0] == '0 || illegal_o)
            else $error("ragged vl accepted");
         a_r5_vstart_enforced: assert (variant_o[0] || vstart_i[EGS_LOG-1:0] == '0 || illegal_o)
            else $error("ragged vstart accepted");
      end
   end
endmodule

// File: tb/vaes_legal_dec_tb.sv
module vaes_legal_dec_tb;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   typedef struct packed {
      logic [31:0] insn;
      logic [2:0]  sew;
      logic [2:0]  lmul;
      logic [15:0] vstart;
      logic [15:0] vl;
      logic        en;
      logic [2:0]  exp_var;
      logic        exp_ill;
      logic [3:0]  req;
   } vec_t;

   function automatic logic [31:0] mk(logic [5:0] f6, logic vm, logic [4:0] vs2,
                                      logic [4:0] mid, logic [6:0] op, logic [4:0] vd);
      return {f6, vm, vs2, mid, 3'b010, vd, op};
   endfunction

   localparam logic [5:0] FVV = 6'b101000, FVS = 6'b101001;
   localparam logic [4:0] MD  = 5'b00011;
   localparam logic [6:0] OP  = 7'b1110111;
   localparam logic [2:0] NN = 3'b001, VV = 3'b010, VS = 3'b100;

   localparam int NV = 25;
   localparam vec_t TBL [NV] = '{
      '{mk(FVV,1,8,MD,OP,4),  3'd2, 3'd0, 16'd0, 16'd8, 1'b1, VV, 1'b0, 4'd1},  // R1
      '{mk(FVS,1,8,MD,OP,4),  3'd2, 3'd0, 16'd0, 16'd8, 1'b1, VS, 1'b0, 4'd2},  // R2
      '{mk(FVV,0,8,MD,OP,4),  3'd2, 3'd0, 16'd0, 16'd8, 1'b1, NN, 1'b0, 4'd3},  // R3 vm=0
      '{mk(FVV,1,8,MD,7'b1010111,4), 3'd2, 3'd0, 16'd0, 16'd8, 1'b1, NN, 1'b0, 4'd3}, // R3
      '{mk(FVV,1,8,5'b00010,OP,4),   3'd2, 3'd0, 16'd0, 16'd8, 1'b1, NN, 1'b0, 4'd3}, // R3
      '{mk(6'b101010,1,8,MD,OP,4),   3'd3, 3'd0, 16'd1, 16'd5, 1'b0, NN, 1'b0, 4'd3}, // R3
      '{mk(FVV,1,8,MD,OP,4),  3'd3, 3'd0, 16'd0, 16'd8, 1'b1, VV, 1'b1, 4'd4},  // R4
      '{mk(FVS,1,8,MD,OP,4),  3'd1, 3'd0, 16'd0, 16'd8, 1'b1, VS, 1'b1, 4'd4},  // R4
      '{mk(FVV,1,8,MD,OP,4),  3'd2, 3'd0, 16'd2, 16'd8, 1'b1, VV, 1'b1, 4'd5},  // R5
      '{mk(FVS,1,8,MD,OP,4),  3'd2, 3'd0, 16'd8, 16'd8, 1'b1, VS, 1'b0, 4'd5},  // R5
      '{mk(FVV,1,8,MD,OP,4),  3'd2, 3'd0, 16'd0, 16'd8, 1'b0, VV, 1'b1, 4'd6},  // R6
      '{mk(FVV,1,8,MD,OP,4),  3'd2, 3'd2, 16'd0, 16'd8, 1'b1, VV, 1'b0, 4'd7},  // R7
      '{mk(FVV,1,8,MD,OP,6),  3'd2, 3'd2, 16'd0, 16'd8, 1'b1, VV, 1'b1, 4'd7},  // R7
      '{mk(FVV,1,5,MD,OP,3),  3'd2, 3'b111, 16'd0, 16'd8, 1'b1, VV, 1'b0, 4'd7}, // R7 fractional
      '{mk(FVV,1,3,MD,OP,2),  3'd2, 3'd1, 16'd0, 16'd8, 1'b1, VV, 1'b1, 4'd8},  // R8
      '{mk(FVS,1,3,MD,OP,2),  3'd2, 3'd1, 16'd0, 16'd8, 1'b1, VS, 1'b1, 4'd9},  // R9 share one
      '{mk(FVS,1,5,MD,OP,2),  3'd2, 3'd1, 16'd0, 16'd8, 1'b1, VS, 1'b0, 4'd9},  // R9 vs2 unaligned ok
      '{mk(FVS,1,4,MD,OP,4),  3'd2, 3'd0, 16'd0, 16'd8, 1'b1, VS, 1'b1, 4'd9},  // R9 same reg
      '{mk(FVS,1,16,MD,OP,8), 3'd2, 3'd3, 16'd0, 16'd8, 1'b1, VS, 1'b0, 4'd9},  // R9 touching
      '{mk(FVS,1,15,MD,OP,8), 3'd2, 3'd3, 16'd0, 16'd8, 1'b1, VS, 1'b1, 4'd9},  // R9
      '{mk(FVS,1,30,MD,OP,24),3'd2, 3'd3, 16'd0, 16'd8, 1'b1, VS, 1'b1, 4'd9},  // R9 top
      '{mk(FVS,1,0,MD,OP,31), 3'd2, 3'd0, 16'd0, 16'd8, 1'b1, VS, 1'b0, 4'd9},  // R9 far
      '{mk(FVV,1,8,MD,OP,4),  3'd2, 3'd0, 16'd0, 16'd6, 1'b1, VV, 1'b1, 4'd10}, // R10
      '{mk(FVS,1,8,MD,OP,4),  3'd2, 3'd0, 16'd0, 16'd5, 1'b1, VS, 1'b1, 4'd10}, // R10
      '{mk(FVV,1,8,MD,OP,24), 3'd2, 3'd3, 16'd4, 16'd0, 1'b1, VV, 1'b0, 4'd7}   // R7
   };

   logic [31:0] insn;
   logic [2:0]  sew, lmul, variant;
   logic [15:0] vstart, vl;
   logic        en, illegal;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   vaes_legal_dec u_dut (
      .insn_i(insn), .sew_i(sew), .lmul_i(lmul), .vstart_i(vstart), .vl_i(vl),
      .crypto_en_i(en), .variant_o(variant), .illegal_o(illegal)
   );

   task automatic check(input logic [2:0] ev, input logic ei, input int req);
      n_chk++;
      if (variant !== ev || illegal !== ei) begin
         n_bad++;
         $display("FAIL R%0d: variant=%b illegal=%b expected variant=%b illegal=%b",
                  req, variant, illegal, ev, ei);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      insn = '0; sew = '0; lmul = '0; vstart = '0; vl = '0; en = 1'b0;
      @(negedge clk);
      check(NN, 1'b0, 3);  // R3: idle all-zero inputs
      foreach (TBL[i]) begin
         @(posedge clk);
         insn = TBL[i].insn; sew = TBL[i].sew; lmul = TBL[i].lmul;
         vstart = TBL[i].vstart; vl = TBL[i].vl; en = TBL[i].en;
         @(negedge clk);
         check(TBL[i].exp_var, TBL[i].exp_ill, int'(TBL[i].req));  // R11 one-hot codes
      end
      // R9: full overlap sweep at four-register groups, aligned destinations
      for (int d = 0; d < 32; d += 4) begin
         for (int s = 0; s < 32; s++) begin
            @(posedge clk);
            insn = mk(FVS, 1'b1, 5'(s), MD, OP, 5'(d));
            sew = 3'd2; lmul = 3'd2; vstart = '0; vl = 16'd16; en = 1'b1;
            @(negedge clk);
            check(VS, ((d < s + 4) && (s < d + 4)) ? 1'b1 : 1'b0, 9);
         end
      end
      // R8: vector-vector source alignment sweep at two-register groups
      for (int s = 0; s < 32; s++) begin
         @(posedge clk);
         insn = mk(FVV, 1'b1, 5'(s), MD, OP, 5'd0);
         sew = 3'd2; lmul = 3'd1; vstart = '0; vl = 16'd4; en = 1'b1;
         @(negedge clk);
         check(VV, (s % 2 != 0) ? 1'b1 : 1'b0, 8);
      end
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end
endmodule